// File: doc/BRIEF.md
# Audio Capture Register and Interrupt Interface

This block is the software-facing register file of a multichannel audio capture peripheral. A host reaches it through a simple one-cycle access strobe with word-aligned byte addresses. The block holds the mode and configuration words that steer the filter datapath, a small receive queue that the datapath fills with finished samples, an interrupt mask that is set and cleared through two separate write-one ports, and a status word whose error bits are sticky until they are read.

Samples arrive on a valid/ready stream. The queue lowers `smp_ready` while it is full. The source is a free-running audio pipe and does not hold its beat: a beat that is offered while `smp_ready` is low is lost and recorded as an overrun. Each host read of the receive register removes the oldest sample. A read of an empty queue returns zero and is recorded as an underrun. A control write with bit 0 set returns the whole block to its reset state and sends a one-cycle reset pulse to the datapath.

Top module: `capt_regif`

## Requirements
- R1: After reset, `mode_o` and `cfg_o` are 0, `irq_o` is 0, `smp_ready` is 1, `swrst_o` is 0, and reads return 0 for mode, configuration and mask and 0x2 (queue empty) for status.
- R2: The mode word (offset 0x04) keeps only the bits in 0xFFF3000F. The configuration word (offset 0x08) keeps only the bits in 0x00550055. Both read back what they hold and drive it on `mode_o` and `cfg_o`. They change only on a write to their own offset or on a software reset.
- R3: Writing ones to offset 0x14 sets those bits of the 6-bit mask. Writing ones to offset 0x18 clears them. Offset 0x1C reads the mask, and writes to 0x1C are ignored.
- R4: `irq_o` is 1 exactly when some bit of status AND mask is 1.
- R5: Status bits 0 to 3 are levels. Bit 0 is 1 when the queue is not empty, bit 1 when it is empty and bit 2 when it is full. Bit 3 is 1 when the queue count is at least the chunk threshold in mode bits [31:28], where a threshold of 0 counts as 1.
- R6: A read of offset 0x0C returns the oldest queued sample, zero-extended to 32 bits, and removes it. Samples leave in arrival order.
- R7: A read of 0x0C while the queue is empty returns 0 and sets status bit 4. While the queue is full, `smp_ready` is 0, and a beat offered then is dropped and sets status bit 5.
- R8: A status read (offset 0x20) returns the status in effect before the read and then clears bits 4 and 5. An underrun or overrun in the same cycle as that read stays set.
- R9: A write to offset 0x00 with bit 0 set clears mode, configuration, mask, queue and sticky bits at the next edge. At that same edge `swrst_o` rises for one cycle. A write to 0x00 with bit 0 clear has no effect.
- R10: Offset 0x50 reads VERSION in bits [11:0] and zero above. Reads of 0x00, 0x14, 0x18, unmapped offsets or unaligned addresses return 0. Writes to read-only, unmapped or unaligned addresses change nothing.
- R11: `bus_rvalid` is 1 for exactly the cycle after each read access, with `bus_rdata` valid, and it stays 0 after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is 1 |
| bus_rvalid | output | 1 | Read response strobe |
| smp_valid | input | 1 | Datapath offers a sample |
| smp_ready | output | 1 | Queue can accept a sample |
| smp_data | input | DATA_W | Sample word from the datapath |
| mode_o | output | 32 | Mode word to the datapath |
| cfg_o | output | 32 | Configuration word to the datapath |
| swrst_o | output | 1 | One-cycle reset pulse to the datapath |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check several relations. Read responses follow read accesses exactly one cycle later. The mode word moves only when the host writes. A raised interrupt always has a mask bit behind it. The reset pulse comes only from a control write with bit 0 set, and it appears with cleared mode and configuration and an accepting queue. The bench scenarios cover the parts that need history: sample order through the queue, the level flags at each fill, what a status read clears, a drop or underrun in the same cycle as a status read, and how unaligned or read-only accesses are treated.

// File: rtl/capt_regif_pkg.sv
package capt_regif_pkg;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_CFG  = 8'h08;
  localparam logic [7:0] OFS_RXD  = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_IDIS = 8'h18;
  localparam logic [7:0] OFS_IMSK = 8'h1C;
  localparam logic [7:0] OFS_ISTS = 8'h20;
  localparam logic [7:0] OFS_VER  = 8'h50;

  localparam int IRQ_W   = 6;
  localparam int IRQ_RDY = 0;
  localparam int IRQ_EMP = 1;
  localparam int IRQ_FUL = 2;
  localparam int IRQ_CHK = 3;
  localparam int IRQ_UDR = 4;
  localparam int IRQ_OVR = 5;

  localparam logic [31:0] MODE_WMASK = 32'hFFF3_000F;
  localparam logic [31:0] CFG_WMASK  = 32'h0055_0055;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MODE,
    SEL_CFG,
    SEL_RXD,
    SEL_IEN,
    SEL_IDIS,
    SEL_IMSK,
    SEL_ISTS,
    SEL_VER
  } reg_sel_e;

endpackage

// File: rtl/capt_addr_dec.sv
module capt_addr_dec
  import capt_regif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

  logic upper_zero;
  logic [7:0] low;

  generate
    if (ADDR_W > 8) begin : g_wide
      assign upper_zero = (addr[ADDR_W-1:8] == HI_W'(0));
      assign low = addr[7:0];
    end else begin : g_narrow
      assign upper_zero = 1'b1;
      assign low = 8'(addr);
    end
  endgenerate

  always_comb begin
    sel = SEL_NONE;
    if (upper_zero && low[1:0] == 2'b00) begin
      case (low)
        OFS_CTRL: sel = SEL_CTRL;
        OFS_MODE: sel = SEL_MODE;
        OFS_CFG:  sel = SEL_CFG;
        OFS_RXD:  sel = SEL_RXD;
        OFS_IEN:  sel = SEL_IEN;
        OFS_IDIS: sel = SEL_IDIS;
        OFS_IMSK: sel = SEL_IMSK;
        OFS_ISTS: sel = SEL_ISTS;
        OFS_VER:  sel = SEL_VER;
        default:  sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/capt_rx_fifo.sv
module capt_rx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          pop,
  output logic [DATA_W-1:0]             out_data,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          empty,
  output logic                          full,
  output logic                          ovr_evt,
  output logic                          udr_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              push, take;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign empty    = (cnt == '0);
  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign take     = pop && !empty;
  assign ovr_evt  = in_valid && full;
  assign udr_evt  = pop && empty;
  assign out_data = mem[rp];
  assign count    = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (take) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/capt_irq_ctrl.sv
module capt_irq_ctrl
  import capt_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] wbits,
  input  logic [3:0]       lvl,
  input  logic             udr_evt,
  input  logic             ovr_evt,
  input  logic             sts_rd,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  logic [IRQ_W-1:0] mask_q;
  logic             udr_q, ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      udr_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (flush) begin
      mask_q <= '0;
      udr_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (set_we) mask_q <= mask_q | wbits;
      else if (clr_we) mask_q <= mask_q & ~wbits;
      udr_q <= (udr_q && !sts_rd) || udr_evt;
      ovr_q <= (ovr_q && !sts_rd) || ovr_evt;
    end
  end

  always_comb begin
    status          = '0;
    status[3:0]     = lvl;
    status[IRQ_UDR] = udr_q;
    status[IRQ_OVR] = ovr_q;
  end

  assign mask = mask_q;
  assign irq  = |(status & mask_q);
endmodule

// File: rtl/capt_regif.sv
module capt_regif
  import capt_regif_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter int          DEPTH   = 4,
  parameter logic [11:0] VERSION = 12'h1C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic [31:0]       mode_o,
  output logic [31:0]       cfg_o,
  output logic              swrst_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int CMP_W = (CNT_W > 4) ? CNT_W : 4;

  reg_sel_e          sel;
  logic              wr, rd, flush;
  logic [31:0]       mode_q, cfg_q, rdata_d;
  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  cnt;
  logic              empty, full, ovr_evt, udr_evt;
  logic [3:0]        thr;
  logic              chunk_ok;
  logic [IRQ_W-1:0]  status, imr_w;

  capt_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr    = bus_valid && bus_write;
  assign rd    = bus_valid && !bus_write;
  assign flush = wr && (sel == SEL_CTRL) && bus_wdata[0];

  capt_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_valid (smp_valid),
    .in_ready (smp_ready),
    .in_data  (smp_data),
    .pop      (rd && (sel == SEL_RXD)),
    .out_data (head),
    .count    (cnt),
    .empty    (empty),
    .full     (full),
    .ovr_evt  (ovr_evt),
    .udr_evt  (udr_evt)
  );

  assign thr      = (mode_q[31:28] == 4'd0) ? 4'd1 : mode_q[31:28];
  assign chunk_ok = (CMP_W'(cnt) >= CMP_W'(thr));

  capt_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .set_we  (wr && (sel == SEL_IEN)),
    .clr_we  (wr && (sel == SEL_IDIS)),
    .wbits   (bus_wdata[IRQ_W-1:0]),
    .lvl     ({chunk_ok, full, empty, !empty}),
    .udr_evt (udr_evt),
    .ovr_evt (ovr_evt),
    .sts_rd  (rd && (sel == SEL_ISTS)),
    .status  (status),
    .mask    (imr_w),
    .irq     (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cfg_q  <= '0;
    end else if (flush) begin
      mode_q <= '0;
      cfg_q  <= '0;
    end else if (wr) begin
      if (sel == SEL_MODE) mode_q <= bus_wdata & MODE_WMASK;
      if (sel == SEL_CFG)  cfg_q  <= bus_wdata & CFG_WMASK;
    end
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_MODE: rdata_d = mode_q;
      SEL_CFG:  rdata_d = cfg_q;
      SEL_RXD:  rdata_d = empty ? 32'd0 : 32'(head);
      SEL_IMSK: rdata_d = 32'(imr_w);
      SEL_ISTS: rdata_d = 32'(status);
      SEL_VER:  rdata_d = {20'd0, VERSION};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      swrst_o    <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rdata_d;
      swrst_o <= flush;
    end
  end

  assign mode_o = mode_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/capt_regif_chk.sv
module capt_regif_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic              smp_ready,
  input logic [31:0]       mode_o,
  input logic [31:0]       cfg_o,
  input logic              swrst_o,
  input logic              irq_o,
  input logic [5:0]        imr
);
  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);  // R11

  AST_NO_RVALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);  // R11

  AST_MODE_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid && bus_write) |-> $stable(mode_o));  // R2

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (imr != 6'd0));  // R4

  AST_SWRST_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_o |-> $past(bus_valid && bus_write && bus_addr == ADDR_W'(0) && bus_wdata[0]));  // R9

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_o |-> (mode_o == 32'd0 && cfg_o == 32'd0 && smp_ready));  // R9
endmodule

bind capt_regif capt_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .smp_ready  (smp_ready),
  .mode_o     (mode_o),
  .cfg_o      (cfg_o),
  .swrst_o    (swrst_o),
  .irq_o      (irq_o),
  .imr        (imr_w)
);

// File: tb/sim_capt_regif.sv
`timescale 1ns/1ps
module sim_capt_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [31:0] smp_data = '0;
  logic [31:0] mode_o, cfg_o;
  logic        swrst_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  capt_regif u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .mode_o(mode_o), .cfg_o(cfg_o), .swrst_o(swrst_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // scoreboard monitor: each read response is matched to the oldest expectation
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("R11 unexpected rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ready", 32'(smp_ready), 1);
    chk("R1 swrst", 32'(swrst_o), 0);
    chk("R1 mode_o", mode_o, 0);
    rd(8'h04, 32'h0, "R1 mode");
    rd(8'h08, 32'h0, "R1 cfg");
    rd(8'h1C, 32'h0, "R1 mask");
    rd(8'h20, 32'h2, "R1 status");

    wr(8'h04, 32'hFFFF_FFFF);
    chk("R2 mode_o", mode_o, 32'hFFF3_000F);
    rd(8'h04, 32'hFFF3_000F, "R2 mode rb");
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R2 cfg_o", cfg_o, 32'h0055_0055);
    rd(8'h08, 32'h0055_0055, "R2 cfg rb");

    wr(8'h04, 32'h2000_0000);
    push(32'hA1);
    rd(8'h20, 32'h1, "R5 one sample");
    push(32'hB2);
    rd(8'h20, 32'h9, "R5 chunk reached");
    push(32'hC3);
    push(32'hD4);
    rd(8'h20, 32'hD, "R5 full");
    chk("R7 ready low when full", 32'(smp_ready), 0);
    push(32'hEE);
    rd(8'h20, 32'h2D, "R7 overrun sticky");
    rd(8'h20, 32'h0D, "R8 cleared by read");

    chk("R4 no mask no irq", 32'(irq_o), 0);
    wr(8'h14, 32'h01);
    chk("R4 irq on rdy", 32'(irq_o), 1);
    rd(8'h1C, 32'h01, "R3 enable");
    wr(8'h1C, 32'h3F);
    rd(8'h1C, 32'h01, "R3 mask write ignored");
    wr(8'h18, 32'h01);
    chk("R4 irq off", 32'(irq_o), 0);
    wr(8'h14, 32'h30);
    rd(8'h1C, 32'h30, "R3 second enable");

    rd(8'h0C, 32'hA1, "R6 first");
    rd(8'h0C, 32'hB2, "R6 second");
    rd(8'h0C, 32'hC3, "R6 third");
    rd(8'h0C, 32'hD4, "R6 fourth");
    rd(8'h20, 32'h2, "R6 drained");
    rd(8'h0C, 32'h0, "R7 empty read");
    chk("R4 irq on underrun", 32'(irq_o), 1);
    rd(8'h20, 32'h12, "R7 underrun sticky");
    chk("R8 irq after clear", 32'(irq_o), 0);

    push(32'h11); push(32'h22); push(32'h33); push(32'h44);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 32'hFF;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h20;
    exp_q.push_back(32'hD); tag_q.push_back("R8 read with drop");
    @(negedge clk);
    smp_valid = 1'b0; bus_valid = 1'b0;
    rd(8'h20, 32'h2D, "R8 coincident overrun kept");
    rd(8'h20, 32'h0D, "R8 then cleared");

    rd(8'h50, 32'h0000_01C3, "R10 version");
    rd(8'h00, 32'h0, "R10 ctrl read");
    rd(8'h14, 32'h0, "R10 enable read");
    rd(8'h18, 32'h0, "R10 disable read");
    rd(8'h10, 32'h0, "R10 unmapped");
    rd(8'h05, 32'h0, "R10 unaligned read");
    wr(8'h20, 32'h3F);
    rd(8'h20, 32'h0D, "R10 status write ignored");
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h04, 32'h2000_0000, "R10 unaligned write ignored");

    wr(8'h00, 32'h0);
    chk("R9 no reset on bit0 clear", mode_o, 32'h2000_0000);
    wr(8'h00, 32'h1);
    chk("R9 swrst pulse", 32'(swrst_o), 1);
    chk("R11 no rvalid after write", 32'(bus_rvalid), 0);
    chk("R9 ready after reset", 32'(smp_ready), 1);
    @(negedge clk);
    chk("R9 swrst one cycle", 32'(swrst_o), 0);
    rd(8'h04, 32'h0, "R9 mode cleared");
    rd(8'h08, 32'h0, "R9 cfg cleared");
    rd(8'h1C, 32'h0, "R9 mask cleared");
    rd(8'h20, 32'h2, "R9 queue flushed");

    repeat (3) @(negedge clk);
    chk("R11 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule